// File: doc/BRIEF.md
# Bayer Neighbourhood Edge Direction Classifier

This block inspects eight raw colour-filter-array samples that surround the pixel being reconstructed. It measures how strongly the image changes along the row and along the column, and from that picks the interpolation style that a downstream colour reconstruction stage should apply. Each sample is compared with a partner through an absolute difference, six times in all. Three of these differences sum to a horizontal gradient and the other three to a vertical gradient. The two gradients then add to a total edge strength.

The total is compared against a threshold supplied with the same neighbourhood. At or below the threshold the pixel is treated as flat. Above it, the weaker of the two gradients names the direction along which interpolation is safe. A new neighbourhood may be presented on every clock. The gradients, total and mode code come out after a fixed four-register pipeline together with a valid flag.

Top module: `cfa_edge_classifier`

## Requirements
- R1: `in_win` packs sample k (k = 0..7) in bits [8k+7:8k], unsigned. The horizontal gradient `out_dh` equals |s0-s1| + |s2-s3| + |s4-s5|.
- R2: The vertical gradient `out_dv` equals |s6-s7| + |s0-s4| + |s1-s5|.
- R3: `out_td` equals `out_dh + out_dv` with no overflow. The gradients are 10 bits and the total is 11 bits, so the largest values (765, 765, 1530) are exact.
- R4: When the total is less than or equal to the threshold sampled with the same neighbourhood, `out_mode` is 2'b00 (flat, no enhancement).
- R5: When the total exceeds the threshold and `out_dh` is less than or equal to `out_dv`, `out_mode` is 2'b01 (enhance along the horizontal).
- R6: When the total exceeds the threshold and `out_dh` is greater than `out_dv`, `out_mode` is 2'b10 (enhance along the vertical). The code 2'b11 never appears.
- R7: A neighbourhood accepted with `in_valid` high at a rising edge produces its results, with `out_valid` high, four rising edges later. Back-to-back inputs give back-to-back outputs, and gaps in `in_valid` reappear as gaps in `out_valid`.
- R8: A synchronous reset (`rst` high at a rising edge) clears `out_valid` and drives all result outputs to zero. Neighbourhoods already in flight are discarded.
- R9: While `out_valid` is low, `out_dh`, `out_dv`, `out_td` and `out_mode` hold the values of the most recent valid result, or zero if none has been produced since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_win` and `in_thr` as a neighbourhood to classify |
| in_win | input | 64 | Eight 8-bit samples, sample k in bits [8k+7:8k] |
| in_thr | input | 11 | Edge strength threshold for this neighbourhood |
| out_valid | output | 1 | Results below belong to an accepted neighbourhood |
| out_dh | output | 10 | Horizontal gradient |
| out_dv | output | 10 | Vertical gradient |
| out_td | output | 11 | Total edge strength |
| out_mode | output | 2 | 00 flat, 01 horizontal, 10 vertical |

## Verification
Every result output and `out_valid` is due at the fourth rising edge after the edge that accepted the neighbourhood. Stimulus is driven on falling edges, and each result is read on the falling edge that follows that fourth rising edge, never at an active edge. In streamed runs the bench keeps a four-deep history of what it drove, so each comparison is made against the neighbourhood sent exactly four cycles earlier. Cycles with no valid output are checked against the last valid result to cover the hold rule.

// File: rtl/cfa_edge_classifier.sv
module cfa_edge_classifier #(
  parameter int SW = 8,
  parameter int NS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [NS*SW-1:0]   in_win,
  input  logic [SW+2:0]      in_thr,
  output logic               out_valid,
  output logic [SW+1:0]      out_dh,
  output logic [SW+1:0]      out_dv,
  output logic [SW+2:0]      out_td,
  output logic [1:0]         out_mode
);
  localparam int GW = SW + 2;
  localparam int TW = GW + 1;
  localparam int ND = 6;
  localparam int NH = 3;
  localparam int PA [ND] = '{0, 2, 4, 6, 0, 1};
  localparam int PB [ND] = '{1, 3, 5, 7, 4, 5};
  localparam logic [1:0] M_FLAT = 2'b00;
  localparam logic [1:0] M_HOR  = 2'b01;
  localparam logic [1:0] M_VER  = 2'b10;

  logic [NS*SW-1:0] s1_win;
  logic [TW-1:0]    s1_thr, s2_thr, s3_thr;
  logic             v1, v2, v3;
  logic [SW-1:0]    ad_n [ND];
  logic [SW-1:0]    s2_ad [ND];
  logic [GW-1:0]    s3_dh, s3_dv;
  logic [TW-1:0]    td_n;
  logic [1:0]       mode_n;

  for (genvar g = 0; g < ND; g++) begin : g_absdiff
    logic [SW-1:0] a, b;
    assign a = s1_win[PA[g]*SW +: SW];
    assign b = s1_win[PB[g]*SW +: SW];
    assign ad_n[g] = (a > b) ? a - b : b - a;
  end

  assign td_n   = TW'(s3_dh) + TW'(s3_dv);
  assign mode_n = (td_n <= s3_thr) ? M_FLAT : (s3_dh <= s3_dv) ? M_HOR : M_VER;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; out_valid <= 1'b0;
      s1_win <= '0; s1_thr <= '0; s2_thr <= '0; s3_thr <= '0;
      for (int i = 0; i < ND; i++) s2_ad[i] <= '0;
      s3_dh <= '0; s3_dv <= '0;
      out_dh <= '0; out_dv <= '0; out_td <= '0; out_mode <= M_FLAT;
    end else begin
      v1 <= in_valid; v2 <= v1; v3 <= v2; out_valid <= v3;
      if (in_valid) begin
        s1_win <= in_win;
        s1_thr <= in_thr;
      end
      if (v1) begin
        for (int i = 0; i < ND; i++) s2_ad[i] <= ad_n[i];
        s2_thr <= s1_thr;
      end
      if (v2) begin
        s3_dh  <= GW'(s2_ad[0]) + GW'(s2_ad[1]) + GW'(s2_ad[NH-1]);
        s3_dv  <= GW'(s2_ad[NH]) + GW'(s2_ad[NH+1]) + GW'(s2_ad[ND-1]);
        s3_thr <= s2_thr;
      end
      if (v3) begin
        out_dh   <= s3_dh;
        out_dv   <= s3_dv;
        out_td   <= td_n;
        out_mode <= mode_n;
      end
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 4));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_td == TW'(out_dh) + TW'(out_dv)));
  p_mode_code_r6: assert property (@(posedge clk) disable iff (rst)
    out_mode != 2'b11);
  p_hor_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == M_HOR) |-> (out_dh <= out_dv));
  p_ver_dir_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == M_VER) |-> (out_dh > out_dv));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(out_td) && $stable(out_mode)));
  p_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_td == '0 && out_mode == M_FLAT));
endmodule

// File: tb/cfa_edge_classifier_test.sv
`timescale 1ns/1ps
module cfa_edge_classifier_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_win = '0;
  logic [10:0] in_thr = '0;
  logic        out_valid;
  logic [9:0]  out_dh, out_dv;
  logic [10:0] out_td;
  logic [1:0]  out_mode;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfa_edge_classifier uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win), .in_thr(in_thr),
    .out_valid(out_valid), .out_dh(out_dh), .out_dv(out_dv), .out_td(out_td),
    .out_mode(out_mode)
  );

  // {samples s7..s0, threshold, dh, dv, td, mode}
  localparam int NV = 9;
  localparam logic [107:0] VEC [NV] = '{
    {64'h0000000000000000, 11'd0,    10'd0,   10'd0,   11'd0,    2'b00},
    {64'h000000FF00FF00FF, 11'd100,  10'd765, 10'd0,   11'd765,  2'b10},
    {64'h00FFFFFF00000000, 11'd100,  10'd0,   10'd765, 11'd765,  2'b01},
    {64'h50463C32281E140A, 11'd0,    10'd30,  10'd90,  11'd120,  2'b01},
    {64'h00000A0A0A0A140A, 11'd19,   10'd10,  10'd10,  11'd20,   2'b01},
    {64'h00000A0A0A0A140A, 11'd20,   10'd10,  10'd10,  11'd20,   2'b00},
    {64'h0005000000C80000, 11'd50,   10'd200, 10'd5,   11'd205,  2'b10},
    {64'hFF0000FF00FF00FF, 11'd2047, 10'd765, 10'd255, 11'd1020, 2'b00},
    {64'hFF0000FFFF00FF00, 11'd1529, 10'd765, 10'd765, 11'd1530, 2'b01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ad(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  // expected {dh, dv, td, mode} from the requirement formulas
  function automatic logic [32:0] model(input logic [63:0] w, input logic [10:0] t);
    logic [7:0] s [8];
    logic [9:0] h, v;
    logic [10:0] d;
    logic [1:0] m;
    for (int k = 0; k < 8; k++) s[k] = w[8*k +: 8];
    h = 10'(ad(s[0], s[1])) + 10'(ad(s[2], s[3])) + 10'(ad(s[4], s[5]));
    v = 10'(ad(s[6], s[7])) + 10'(ad(s[0], s[4])) + 10'(ad(s[1], s[5]));
    d = 11'(h) + 11'(v);
    m = (d <= t) ? 2'b00 : (h <= v) ? 2'b01 : 2'b10;
    return {h, v, d, m};
  endfunction

  task automatic chk_res(input string tag, input logic [32:0] e);
    chk({tag, " R1 dh"}, 32'(out_dh), 32'(e[32:23]));
    chk({tag, " R2 dv"}, 32'(out_dv), 32'(e[22:13]));
    chk({tag, " R3 td"}, 32'(out_td), 32'(e[12:2]));
    chk({tag, " R4/R5/R6 mode"}, 32'(out_mode), 32'(e[1:0]));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [32:0] hist [4];
    logic        hv   [4];
    logic [32:0] last;
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset valid", 32'(out_valid), 0);
    chk_res("R8 reset", 33'd0);

    // table stream, back to back
    for (int i = 0; i < NV + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        chk("R7 valid", 32'(out_valid), 1);
        chk_res($sformatf("vec%0d", i - 4), VEC[i-4][32:0]);
      end
      in_valid = (i < NV);
      if (i < NV) begin
        in_win = VEC[i][107:44];
        in_thr = VEC[i][43:33];
      end else begin
        in_win = 64'hDEADBEEF01234567;
        in_thr = 11'd0;
      end
    end
    // hold after the stream drains
    repeat (2) begin
      @(negedge clk);
      chk("R7 no valid", 32'(out_valid), 0);
      chk_res("R9 hold", VEC[NV-1][32:0]);
    end

    // pseudo-random stream with gaps
    last = VEC[NV-1][32:0];
    for (int k = 0; k < 4; k++) begin hv[k] = 1'b0; hist[k] = '0; end
    lf = 32'h1234ABCD;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      chk("R7 stream valid", 32'(out_valid), 32'(hv[3]));
      if (hv[3]) last = hist[3];
      chk_res(hv[3] ? "stream" : "R9 stream hold", last);
      for (int k = 3; k > 0; k--) begin hv[k] = hv[k-1]; hist[k] = hist[k-1]; end
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      in_valid = (i < 296) && (lf[3:0] != 4'd0);
      in_win = {lf, lf[15:0] ^ lf[31:16], lf[23:8]};
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      in_thr = lf[10:0] & {1'b0, {10{lf[11]}}};
      hv[0] = in_valid;
      hist[0] = model(in_win, in_thr);
    end

    // reset with results in flight
    in_valid = 1'b1;
    in_win = 64'h000000FF00FF00FF;
    in_thr = 11'd0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 mid reset valid", 32'(out_valid), 0);
    chk_res("R8 mid reset", 33'd0);
    repeat (5) begin
      @(negedge clk);
      chk("R8 flushed valid", 32'(out_valid), 0);
      chk_res("R8 flushed", 33'd0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule